// File: doc/BRIEF.md
# Framed Serializer with Sync-Burst Generator

The block takes a ten-bit parallel word once per word period and sends it as a twelve-slot frame on one serial line. The clock runs at the bit rate; an internal slot counter splits it into word periods and also drives a word-clock output, high for the first half of each frame. Each frame carries a high start bit, then the data bits from bit 0 upward, then a low stop bit. The fixed-polarity edges at the frame boundary act as an embedded clock for a receiver.

A receiver can lock quickly if the sender transmits a known pattern. The block provides two request inputs for this, combined by OR. If the request is held long enough, the block sends a fixed-length burst of synchronization frames (six ones, then six zeros) and ignores the parallel data. If the request is still held when the burst ends, sync frames continue until it drops. Power-down freezes the block. Leaving power-down starts a fixed reinitialization period, and the output stays invalid until it ends. A driven-versus-high-impedance output is modelled by an output-valid flag.

Top module: `frame_serializer`

## Requirements
- R1: A frame is 12 clock cycles, with slot 0 first. Slot 0 carries 1 (start), slots 1 to 10 carry data bits 0 to 9, and slot 11 carries 0 (stop). `wclk_o` is 1 in slots 0 to 5 and 0 in slots 6 to 11.
- R2: With `cap_rise`=1 the word on `din` is sampled in slot 0. With `cap_rise`=0 it is sampled in slot 6. The sampled word is sent in the frame that starts after the current one ends.
- R3: The request (`sync_a` OR `sync_b`) is sampled once per frame, in slot 11. A burst starts only when 6 consecutive samples are high. Five high samples followed by a low one start nothing.
- R4: A burst sends 1026 consecutive sync frames, each 1 in slots 0 to 5 and 0 in slots 6 to 11. `din` has no effect while the burst runs.
- R5: If the request is still high when a burst ends, sync frames continue until a low sample. After that, a new run of 6 high samples starts a new 1026-frame burst.
- R6: `ser_oe` = `enable` AND NOT `pwr_dn` AND (reinitialization finished) AND NOT `sync_a` AND NOT `sync_b`. `ser_o` is 0 whenever `ser_oe` is 0.
- R7: While `pwr_dn` is high, the slot counter holds at 0 and any burst is cancelled. After reset, or after `pwr_dn` falls, `ser_oe` stays 0 for 1026 frames.
- R8: Toggling `enable` has no effect on the framing, the captured data or the progress of a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 10 | Parallel data word |
| cap_rise | input | 1 | 1: sample on the word-clock rise (slot 0); 0: sample on its fall (slot 6) |
| sync_a | input | 1 | Sync request, first source |
| sync_b | input | 1 | Sync request, second source |
| enable | input | 1 | Output enable |
| pwr_dn | input | 1 | Power-down, active high |
| ser_o | output | 1 | Serial data, 0 when not valid |
| ser_oe | output | 1 | Serial output valid (driven) |
| wclk_o | output | 1 | Word clock, high in slots 0 to 5 |

## Verification
The hardest case is the continuation and re-arm behaviour. The output is invalid for as long as a request is held, so sync frames sent during a held request cannot be seen directly. The stimulus therefore holds a request for longer than a whole burst, drops it, and checks that the very next frame is data. It then applies a fresh six-frame hold and checks that a new burst becomes visible. Separate runs cover a five-frame hold that must not trigger, enable toggling in the middle of a burst, and power-down during a burst.

// File: rtl/fs_pkg.sv
package fs_pkg;
   // Kind of frame held in the output register
   typedef enum logic {
      KIND_DATA = 1'b0,
      KIND_SYNC = 1'b1
   } frame_kind_e;

   // Start and stop bit levels: they form the embedded clock edge
   localparam logic START_LVL = 1'b1;
   localparam logic STOP_LVL  = 1'b0;
endpackage

// File: rtl/fs_slot_timer.sv
module fs_slot_timer #(
   parameter int FRAME_W = 12,
   parameter int SLOT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_dn,
   output logic [SLOT_W-1:0] slot,
   output logic              tick,
   output logic              wclk
);
   localparam logic [SLOT_W-1:0] LAST = SLOT_W'(FRAME_W - 1);
   localparam logic [SLOT_W-1:0] HALF = SLOT_W'(FRAME_W / 2);

   logic [SLOT_W-1:0] slot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            slot_q <= '0;
      else if (pwr_dn)       slot_q <= '0;
      else if (slot_q == LAST) slot_q <= '0;
      else                   slot_q <= slot_q + 1'b1;
   end

   assign slot = slot_q;
   assign tick = (slot_q == LAST);
   assign wclk = (slot_q < HALF);
endmodule

// File: rtl/fs_capture.sv
module fs_capture #(
   parameter int DATA_W  = 10,
   parameter int FRAME_W = 12,
   parameter int SLOT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_dn,
   input  logic              cap_rise,
   input  logic [SLOT_W-1:0] slot,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] word
);
   localparam logic [SLOT_W-1:0] RISE_PT = '0;
   localparam logic [SLOT_W-1:0] FALL_PT = SLOT_W'(FRAME_W / 2);

   logic              take;
   logic [DATA_W-1:0] word_q;

   assign take = !pwr_dn && (cap_rise ? (slot == RISE_PT) : (slot == FALL_PT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    word_q <= '0;
      else if (take) word_q <= din;
   end

   assign word = word_q;
endmodule

// File: rtl/fs_sync_ctrl.sv
module fs_sync_ctrl #(
   parameter int HOLD_WORDS  = 6,
   parameter int BURST_WORDS = 1026,
   parameter int INIT_WORDS  = 1026
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_dn,
   input  logic tick,
   input  logic req,
   output logic load_sync,
   output logic init_done,
   output logic [$clog2(BURST_WORDS+1)-1:0] burst_left
);
   localparam int HOLD_W  = $clog2(HOLD_WORDS + 1);
   localparam int BURST_W = $clog2(BURST_WORDS + 1);
   localparam int INIT_W  = $clog2(INIT_WORDS + 1);
   localparam logic [HOLD_W-1:0]  HOLD_MAX  = HOLD_W'(HOLD_WORDS);
   localparam logic [HOLD_W-1:0]  HOLD_ARM  = HOLD_W'(HOLD_WORDS - 1);
   localparam logic [BURST_W-1:0] BURST_REM = BURST_W'(BURST_WORDS - 1);
   localparam logic [INIT_W-1:0]  INIT_MAX  = INIT_W'(INIT_WORDS);

   logic [HOLD_W-1:0]  hold_q;
   logic [BURST_W-1:0] burst_q;
   logic [INIT_W-1:0]  init_q;
   logic               block_q;   // set by a trigger, cleared by a low request sample
   logic               trig;
   logic [HOLD_W-1:0]  hold_inc;

   assign init_done = (init_q == '0);
   assign hold_inc  = (hold_q == HOLD_MAX) ? HOLD_MAX : hold_q + 1'b1;
   assign trig      = tick && init_done && req && !block_q &&
                      (burst_q == '0) && (hold_q == HOLD_ARM);
   assign load_sync = trig || (burst_q != '0) || (block_q && req);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_q  <= INIT_MAX;
         hold_q  <= '0;
         burst_q <= '0;
         block_q <= 1'b0;
      end else if (pwr_dn) begin
         init_q  <= INIT_MAX;
         hold_q  <= '0;
         burst_q <= '0;
         block_q <= 1'b0;
      end else if (tick) begin
         if (!init_done) begin
            init_q <= init_q - 1'b1;
         end else begin
            hold_q <= req ? hold_inc : '0;
            if (trig)                 burst_q <= BURST_REM;
            else if (burst_q != '0)   burst_q <= burst_q - 1'b1;
            if (trig)                 block_q <= 1'b1;
            else if (!req)            block_q <= 1'b0;
         end
      end
   end

   assign burst_left = burst_q;
endmodule

// File: rtl/fs_shifter.sv
module fs_shifter
   import fs_pkg::*;
#(
   parameter int DATA_W  = 10,
   parameter int FRAME_W = 12,
   parameter int SLOT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_dn,
   input  logic              tick,
   input  logic              load_sync,
   input  logic [DATA_W-1:0] word,
   input  logic [SLOT_W-1:0] slot,
   output logic              ser_raw,
   output logic              is_sync
);
   localparam int HALF = FRAME_W / 2;

   logic [FRAME_W-1:0] data_frame;
   logic [FRAME_W-1:0] sync_frame;
   logic [FRAME_W-1:0] frame_q;
   frame_kind_e        kind_q;

   assign data_frame[0]         = START_LVL;
   assign data_frame[FRAME_W-1] = STOP_LVL;
   for (genvar i = 0; i < DATA_W; i++) begin : g_data_slot
      assign data_frame[i+1] = word[i];
   end
   for (genvar i = 0; i < FRAME_W; i++) begin : g_sync_slot
      assign sync_frame[i] = (i < HALF) ? 1'b1 : 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_q <= '0;
         kind_q  <= KIND_DATA;
      end else if (pwr_dn) begin
         frame_q <= '0;
         kind_q  <= KIND_DATA;
      end else if (tick) begin
         frame_q <= load_sync ? sync_frame : data_frame;
         kind_q  <= load_sync ? KIND_SYNC : KIND_DATA;
      end
   end

   always_comb begin
      ser_raw = 1'b0;
      for (int i = 0; i < FRAME_W; i++) begin
         if (slot == SLOT_W'(i)) ser_raw = frame_q[i];
      end
   end

   assign is_sync = (kind_q == KIND_SYNC);
endmodule

// File: rtl/frame_serializer.sv
module frame_serializer #(
   parameter int DATA_W      = 10,
   parameter int HOLD_WORDS  = 6,
   parameter int BURST_WORDS = 1026,
   parameter int INIT_WORDS  = 1026
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] din,
   input  logic              cap_rise,
   input  logic              sync_a,
   input  logic              sync_b,
   input  logic              enable,
   input  logic              pwr_dn,
   output logic              ser_o,
   output logic              ser_oe,
   output logic              wclk_o
);
   localparam int FRAME_W = DATA_W + 2;
   localparam int SLOT_W  = $clog2(FRAME_W);
   localparam int BURST_W = $clog2(BURST_WORDS + 1);

   if (DATA_W < 2) begin : g_bad_width
      $error("DATA_W must be at least 2");
   end
   if ((FRAME_W % 2) != 0) begin : g_bad_half
      $error("frame length must be even for the half-ones sync pattern");
   end
   if (HOLD_WORDS < 1 || BURST_WORDS < 1 || INIT_WORDS < 1) begin : g_bad_count
      $error("hold, burst and init counts must be positive");
   end

   logic [SLOT_W-1:0]  slot_q;
   logic               tick;
   logic [DATA_W-1:0]  word;
   logic               load_sync;
   logic               init_done;
   logic [BURST_W-1:0] burst_left;
   logic               ser_raw;
   logic               is_sync;
   logic               req;

   assign req = sync_a | sync_b;

   fs_slot_timer #(.FRAME_W(FRAME_W), .SLOT_W(SLOT_W)) timer_i (
      .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn),
      .slot(slot_q), .tick(tick), .wclk(wclk_o)
   );

   fs_capture #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .SLOT_W(SLOT_W)) cap_i (
      .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .cap_rise(cap_rise),
      .slot(slot_q), .din(din), .word(word)
   );

   fs_sync_ctrl #(.HOLD_WORDS(HOLD_WORDS), .BURST_WORDS(BURST_WORDS),
                  .INIT_WORDS(INIT_WORDS)) ctrl_i (
      .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .tick(tick), .req(req),
      .load_sync(load_sync), .init_done(init_done), .burst_left(burst_left)
   );

   fs_shifter #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .SLOT_W(SLOT_W)) shift_i (
      .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .tick(tick),
      .load_sync(load_sync), .word(word), .slot(slot_q),
      .ser_raw(ser_raw), .is_sync(is_sync)
   );

   assign ser_oe = enable && !pwr_dn && init_done && !req;
   assign ser_o  = ser_oe && ser_raw;
endmodule

// File: rtl/fs_checker.sv
module fs_checker #(
   parameter int FRAME_W = 12,
   parameter int SLOT_W  = 4,
   parameter int BURST_W = 11
) (
   input logic               clk,
   input logic               rst_n,
   input logic               pwr_dn,
   input logic               enable,
   input logic               sync_a,
   input logic               sync_b,
   input logic               tick,
   input logic [SLOT_W-1:0]  slot,
   input logic               is_sync,
   input logic               ser_raw,
   input logic               ser_o,
   input logic               oe,
   input logic [BURST_W-1:0] burst_left
);
   localparam logic [SLOT_W-1:0] LAST = SLOT_W'(FRAME_W - 1);
   localparam logic [SLOT_W-1:0] HALF = SLOT_W'(FRAME_W / 2);

   // R1
   start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (oe && slot == '0) |-> ser_o);

   // R1
   stop_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (oe && slot == LAST) |-> !ser_o);

   // R4
   sync_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_sync && !pwr_dn) |-> (ser_raw == (slot < HALF)));

   // R4
   burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !pwr_dn && burst_left != '0) |=> (burst_left == $past(burst_left) - BURST_W'(1)));

   // R6
   gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_dn || !enable || sync_a || sync_b) |-> (!oe && !ser_o));

   // R7
   wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_dn) |-> !oe);

   // R7
   slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(pwr_dn) |-> (slot == '0 && burst_left == '0));
endmodule

bind frame_serializer fs_checker #(.FRAME_W(FRAME_W), .SLOT_W(SLOT_W), .BURST_W(BURST_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .enable(enable),
   .sync_a(sync_a), .sync_b(sync_b), .tick(tick), .slot(slot_q),
   .is_sync(is_sync), .ser_raw(ser_raw), .ser_o(ser_o), .oe(ser_oe),
   .burst_left(burst_left)
);

// File: tb/frame_serializer_tb_top.sv
module frame_serializer_tb_top;
   localparam int CLK_P    = 10;
   localparam int DW       = 10;
   localparam int FW       = DW + 2;
   localparam int HOLD     = 6;
   localparam int BURST    = 1026;
   localparam int INIT     = 1026;
   localparam int WD_LIMIT = 190000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [DW-1:0] din = '0;
   logic          cap_rise = 1'b1;
   logic          sync_a = 1'b0;
   logic          sync_b = 1'b0;
   logic          enable = 1'b0;
   logic          pwr_dn = 1'b0;
   logic          ser_o, ser_oe, wclk_o;

   always #(CLK_P/2) clk = ~clk;

   frame_serializer #(.DATA_W(DW), .HOLD_WORDS(HOLD), .BURST_WORDS(BURST),
                      .INIT_WORDS(INIT)) dut_i (
      .clk(clk), .rst_n(rst_n), .din(din), .cap_rise(cap_rise),
      .sync_a(sync_a), .sync_b(sync_b), .enable(enable), .pwr_dn(pwr_dn),
      .ser_o(ser_o), .ser_oe(ser_oe), .wclk_o(wclk_o)
   );

   int    checks = 0;
   int    failures = 0;
   int    cyc = 0;
   bit    cmp_on = 1'b0;
   bit    done = 1'b0;
   string cur_tag = "R1";

   // Expected-value state, built from the requirements
   int            m_slot, m_init, m_hold, m_burst;
   bit            m_block;
   logic [FW-1:0] m_frame;
   logic [DW-1:0] m_cap;

   function automatic logic [FW-1:0] data_frame(input logic [DW-1:0] w);
      return {1'b0, w, 1'b1};
   endfunction

   function automatic logic [FW-1:0] sync_frame();
      logic [FW-1:0] f = '0;
      for (int i = 0; i < FW/2; i++) f[i] = 1'b1;
      return f;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   task automatic model_clear();
      m_slot = 0; m_init = INIT; m_hold = 0; m_burst = 0;
      m_block = 1'b0; m_frame = '0;
   endtask

   task automatic model_tick();
      bit req, trig, snd;
      req = sync_a | sync_b;
      if (m_init > 0) begin
         m_init--;
         snd = 1'b0;
      end else begin
         trig = req && !m_block && m_burst == 0 && m_hold == HOLD - 1;
         snd  = trig || m_burst > 0 || (m_block && req);
         m_hold = req ? ((m_hold < HOLD) ? m_hold + 1 : HOLD) : 0;
         if (trig) m_burst = BURST - 1;
         else if (m_burst > 0) m_burst--;
         if (trig) m_block = 1'b1;
         else if (!req) m_block = 1'b0;
      end
      m_frame = snd ? sync_frame() : data_frame(m_cap);
   endtask

   always @(posedge clk) begin
      bit exp_oe;
      if (!rst_n) begin
         model_clear();
         m_cap = '0;
      end else if (pwr_dn) begin
         model_clear();
      end else begin
         if ((cap_rise && m_slot == 0) || (!cap_rise && m_slot == FW/2)) m_cap = din;
         if (m_slot == FW - 1) begin
            model_tick();
            m_slot = 0;
         end else begin
            m_slot++;
         end
      end
      #(CLK_P/4);
      if (cmp_on && rst_n && !done) begin
         exp_oe = enable && !pwr_dn && m_init == 0 && !sync_a && !sync_b;
         chk("R6", ser_oe, exp_oe);
         chk(cur_tag, ser_o, exp_oe & m_frame[m_slot]);
         chk("R1", wclk_o, (m_slot < FW/2));
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > WD_LIMIT && !done) begin
         failures++;
         $display("FAIL R7 watchdog act=%0d exp<=%0d", cyc, WD_LIMIT);
         finish_run();
      end
   end

   task automatic frames(input int n);
      repeat (n * FW) @(negedge clk);
   endtask

   task automatic align();
      @(negedge clk);
      while (m_slot != 0) @(negedge clk);
   endtask

   task automatic rand_frames(input int n, input bit flip_edge, input bit flip_en);
      for (int f = 0; f < n; f++) begin
         if (flip_edge) cap_rise = $urandom_range(0, 1);
         for (int c = 0; c < FW; c++) begin
            @(negedge clk);
            din = DW'($urandom);
            if (flip_en && ($urandom_range(0, 6) == 0)) enable = ~enable;
         end
      end
   endtask

   initial begin
      void'($urandom(32'd4711));
      repeat (4) @(negedge clk);
      // R7: reset state
      chk("R7", ser_oe, 1'b0);
      chk("R7", ser_o, 1'b0);
      rst_n = 1'b1;
      cmp_on = 1'b1;
      enable = 1'b1;
      // R7: reinitialization window after reset
      frames(INIT - 2);
      chk("R7", ser_oe, 1'b0);
      frames(4);
      chk("R7", ser_oe, 1'b1);

      // R1: framing with one word per frame
      cur_tag = "R1";
      for (int f = 0; f < 40; f++) begin
         @(negedge clk);
         din = DW'($urandom);
         frames(1);
      end
      // R2: capture point by edge mode, din changing every cycle
      cur_tag = "R2";
      rand_frames(80, 1'b1, 1'b0);
      cap_rise = 1'b1;

      // R3: a five-frame hold must not trigger
      cur_tag = "R3";
      align();
      sync_a = 1'b1;
      frames(HOLD - 1);
      sync_a = 1'b0;
      rand_frames(4, 1'b0, 1'b0);
      // R3: a six-frame hold triggers
      align();
      sync_b = 1'b1;
      frames(HOLD);
      sync_b = 1'b0;
      frames(1);
      chk("R3", ser_oe, 1'b1);
      // R4: burst ignores data
      cur_tag = "R4";
      rand_frames(1000, 1'b1, 1'b0);
      // R8: enable toggles through the burst end
      cur_tag = "R8";
      rand_frames(40, 1'b0, 1'b1);
      enable = 1'b1;
      rand_frames(20, 1'b0, 1'b0);

      // R5: hold past a whole burst, then drop, then re-arm
      cur_tag = "R5";
      align();
      sync_a = 1'b1;
      frames(BURST + 14);
      sync_a = 1'b0;
      rand_frames(6, 1'b0, 1'b0);
      align();
      sync_b = 1'b1;
      frames(HOLD);
      sync_b = 1'b0;
      rand_frames(30, 1'b0, 1'b0);

      // R7: power-down during a burst, then reinitialization
      cur_tag = "R7";
      pwr_dn = 1'b1;
      frames(3);
      chk("R7", ser_oe, 1'b0);
      chk("R7", wclk_o, 1'b1);
      pwr_dn = 1'b0;
      frames(INIT - 6);
      chk("R7", ser_oe, 1'b0);
      frames(10);
      chk("R7", ser_oe, 1'b1);
      rand_frames(10, 1'b0, 1'b0);

      cmp_on = 1'b0;
      @(negedge clk);
      finish_run();
   end
endmodule